// File: doc/BRIEF.md
# I2C Write-Only Control Register Slave

This block lets an external I2C master program a bank of 8-bit control registers. The bus lines are oversampled by the system clock. A START or STOP condition is recognised wherever it occurs on the bus. The slave answers to a 7-bit device address that has a fixed five-bit prefix and two strap-pin bits. After a matching write address, the next byte loads an internal register pointer. Each byte after that is stored at the pointer, and the pointer then advances. At the top of the bank the pointer wraps to zero, and the limit does not have to be a power of two.

The register contents are exposed as one flat vector that the surrounding logic reads directly. Every store also gives a one-cycle strobe that carries the register index and the data byte. SDA is an open-drain output: the enable only ever pulls the line low. A read request is acknowledged, but no data is returned.

Top module: `i2c_regbank_slave`

## Requirements
- R1: START (SDA falling while SCL is high) begins address reception. The first byte is sent MSB first. Bits 7..3 must be 00100, bits 2..1 must equal `strap_i[1:0]`, and bit 0 is R/W (0 means write). On a match the slave acknowledges.
- R2: On an address mismatch the slave never pulls SDA low and writes no register until the next START.
- R3: For each accepted byte, SDA is pulled low from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth clock. The enable changes only after an SCL falling edge, or after a START or STOP.
- R4: The second byte loads the register pointer with its value. A value above the last index (47 by default) loads 0.
- R5: Each byte from the third onward is sampled MSB first on SCL rising edges. It is stored at the pointer, and a one-cycle `wr_stb_o` reports the index and the data. Registers change only together with this strobe.
- R6: After each store the pointer advances by one. From the last index (0x2F) it wraps to 0x00, and the earlier registers are overwritten.
- R7: STOP (SDA rising while SCL is high) returns the slave to idle, releases SDA and discards a partially received byte.
- R8: A repeated START in the middle of a byte abandons that byte and restarts address reception.
- R9: An address with R/W=1 is acknowledged. After that the slave keeps SDA released and stores nothing until the next START.
- R10: After reset all registers read 0, SDA is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 2 | Pin-strapped low device-address bits |
| sda_oe_o | output | 1 | Pull-down enable for SDA (1 = drive low) |
| regs_o | output | NUM_REGS*8 | Register contents, register k at bits [8k+7:8k] |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_addr_o | output | PTR_W | Index of the register just written |
| wr_data_o | output | 8 | Byte just written |

## Verification
The assertions take for granted a well-behaved master. SDA moves only while SCL is low, except for START and STOP. Each SCL level is held for many system clocks longer than the two-flop synchronizer delay, so every edge and condition appears as exactly one detected event. The master releases SDA during the acknowledge clock. The bench keeps within these limits: each SCL quarter period lasts ten system clocks, and inputs are changed only on falling system-clock edges. The aborted-byte scenarios also follow them, because they generate STOP and repeated START only from the SCL-low phase.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_REG,
    K_DATA,
    K_READ
  } byte_kind_t;

  // device address compare: fixed prefix then strap bits
  function automatic logic dev_match(input logic [6:0] addr7,
                                     input logic [4:0] prefix,
                                     input logic [1:0] strap);
    return addr7 == {prefix, strap};
  endfunction

  // pointer value taken from the register-address byte
  function automatic logic [7:0] ptr_from_byte(input logic [7:0] b,
                                               input logic [7:0] last);
    return (b > last) ? 8'd0 : b;
  endfunction

  // post-store pointer advance with wrap at the last index
  function automatic logic [7:0] ptr_step(input logic [7:0] p,
                                          input logic [7:0] last);
    return (p >= last) ? 8'd0 : p + 8'd1;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      scl_q    <= scl_pipe[TOP];
      sda_q    <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_bus_fsm.sv
`timescale 1ns/1ps
module i2cs_bus_fsm
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS = 48,
  parameter logic [4:0] PREFIX   = 5'b00100,
  parameter int         PTR_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             byte_done,
  output logic             dev_nack,
  output logic             wr_req,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] LAST8 = 8'(NUM_REGS - 1);

  bus_state_t       state;
  byte_kind_t       kind;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rx_byte;
  logic             addr_hit;

  assign rx_byte   = {shreg, sda_s};
  assign byte_done = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
  assign addr_hit  = dev_match(rx_byte[7:1], PREFIX, strap);
  assign dev_nack  = byte_done && (kind == K_DEV) && !addr_hit;
  assign wr_req    = byte_done && (kind == K_DATA);
  assign wr_addr   = ptr;
  assign wr_data   = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= K_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      kind    <= K_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= {shreg[5:0], sda_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            unique case (kind)
              K_DEV: begin
                if (addr_hit) begin
                  kind  <= rx_byte[0] ? K_READ : K_REG;
                  state <= ST_ACK_SETUP;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              K_REG: begin
                ptr   <= PTR_W'(ptr_from_byte(rx_byte, LAST8));
                kind  <= K_DATA;
                state <= ST_ACK_SETUP;
              end
              K_DATA: begin
                ptr   <= PTR_W'(ptr_step(8'(ptr), LAST8));
                state <= ST_ACK_SETUP;
              end
              default: state <= ST_IGNORE;
            endcase
          end
        end
        ST_ACK_SETUP: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          state   <= (kind == K_READ) ? ST_IGNORE : ST_RX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_reg_store.sv
`timescale 1ns/1ps
module i2cs_reg_store #(
  parameter int NUM_REGS = 48,
  parameter int PTR_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic                  wr_stb,
  output logic [PTR_W-1:0]      wr_addr_q,
  output logic [7:0]            wr_data_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_flat[g*8 +: 8] <= '0;
      else if (wr_req && wr_addr == PTR_W'(g))
        regs_flat[g*8 +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb    <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_stb <= wr_req;
      if (wr_req) begin
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave #(
  parameter int         NUM_REGS = 48,
  parameter logic [4:0] PREFIX   = 5'b00100,
  localparam int        PTR_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [PTR_W-1:0]      wr_addr_o,
  output logic [7:0]            wr_data_o
);
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             byte_done, dev_nack, wr_req;
  logic [PTR_W-1:0] wr_addr;
  logic [7:0]       wr_data;

  i2cs_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_bus_fsm #(.NUM_REGS(NUM_REGS), .PREFIX(PREFIX), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strap(strap_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .byte_done(byte_done), .dev_nack(dev_nack),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2cs_reg_store #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(regs_o), .wr_stb(wr_stb_o),
    .wr_addr_q(wr_addr_o), .wr_data_q(wr_data_o)
  );

  // scl_s is consumed only through the derived edge and condition wires
  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2cs_regbank_chk.sv
`timescale 1ns/1ps
module i2cs_regbank_chk #(
  parameter int NUM_REGS = 48,
  parameter int PTR_W    = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_fall,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  byte_done,
  input logic                  dev_nack,
  input logic                  sda_oe_o,
  input logic                  wr_stb_o,
  input logic [PTR_W-1:0]      wr_addr_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  // R3
  ack_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R3
  ack_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

  // R2
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nack |=> !sda_oe_o);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R5
  regs_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> wr_stb_o);

  // R6
  wr_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> wr_addr_o <= LAST);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o && !wr_stb_o);

  // R8
  restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  // R5
  store_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(byte_done));
endmodule

bind i2c_regbank_slave i2cs_regbank_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .byte_done(byte_done), .dev_nack(dev_nack),
  .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
  .regs_o(regs_o)
);

// File: tb/i2c_regbank_slave_test.sv
`timescale 1ns/1ps
module i2c_regbank_slave_test;
  localparam int NREG = 48;
  localparam int AW   = 6;
  localparam int Q    = 10;            // system clocks per SCL quarter
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] DEV_WR = 8'h24;   // 0010010 + W
  localparam logic [7:0] DEV_RD = 8'h25;   // 0010010 + R
  localparam logic [7:0] DEV_BAD = 8'h26;  // 0010011 + W

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe_o, wr_stb_o;
  logic [NREG*8-1:0] regs_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  i2c_regbank_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe_o), .regs_o(regs_o),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  int last_a = -1;
  int last_d = -1;
  logic [7:0] exp_reg [NREG];
  int m_ptr = 0;

  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      stb_cnt++;
      last_a = int'(wr_addr_o);
      last_d = int'(wr_data_o);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b1; wait_q(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wait_q(1);
    scl_m = 1'b1; wait_q(2);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    acked = !sda_line;
    wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++)
      check(regs_o[k*8 +: 8] == exp_reg[k], req, int'(regs_o[k*8 +: 8]), int'(exp_reg[k]));
  endtask

  // data byte with model update: pointer advances modulo the bank size
  task automatic send_data(input logic [7:0] b, input string req);
    bit ak;
    send_byte(b, ak);
    check(ak, req, int'(ak), 1);
    exp_reg[m_ptr] = b;
    m_ptr = (m_ptr + 1) % NREG;
  endtask

  task automatic open_write(input logic [7:0] regaddr, input string req);
    bit ak;
    bus_start();
    send_byte(DEV_WR, ak);
    check(ak, req, int'(ak), 1);
    send_byte(regaddr, ak);
    check(ak, req, int'(ak), 1);
    m_ptr = (int'(regaddr) < NREG) ? int'(regaddr) : 0;
  endtask

  task automatic t_reset;
    // R10
    check(sda_oe_o == 1'b0, "R10 sda released", int'(sda_oe_o), 0);
    check(wr_stb_o == 1'b0, "R10 no strobe", int'(wr_stb_o), 0);
    check(regs_o == '0, "R10 regs zero", int'(regs_o[7:0]), 0);
  endtask

  task automatic t_basic_write;
    int s0 = stb_cnt;
    // R1 R3 R4 R5: address ack, pointer load, two stores
    open_write(8'h05, "R1 addr ack");
    send_data(8'hA5, "R3 data ack");
    send_data(8'h3C, "R3 data ack");
    bus_stop();
    check(stb_cnt - s0 == 2, "R5 strobe count", stb_cnt - s0, 2);
    check(last_a == 6, "R5 strobe index", last_a, 6);
    check(last_d == 8'h3C, "R5 strobe data", last_d, 8'h3C);
    check_regs("R4 R5 basic burst");
  endtask

  task automatic t_ack_window;
    bit ak;
    // R3: enable is low through bits, high only around the ninth clock
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      put_bit(DEV_WR[i]);
      if (i > 0) check(sda_oe_o == 1'b0, "R3 no drive during bits", int'(sda_oe_o), 0);
    end
    check(sda_oe_o == 1'b1, "R3 drive after eighth fall", int'(sda_oe_o), 1);
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    ak = !sda_line;
    check(ak, "R3 ack seen on line", int'(ak), 1);
    wait_q(1);
    scl_m = 1'b0; wait_q(1);
    check(sda_oe_o == 1'b0, "R3 release after ninth fall", int'(sda_oe_o), 0);
    bus_stop();
  endtask

  task automatic t_wrong_addr;
    bit ak;
    int s0 = stb_cnt;
    // R2
    bus_start();
    send_byte(DEV_BAD, ak);
    check(!ak, "R2 mismatch nack", int'(ak), 0);
    send_byte(8'h02, ak);
    check(!ak, "R2 ignored byte nack", int'(ak), 0);
    send_byte(8'h99, ak);
    check(!ak, "R2 ignored byte nack", int'(ak), 0);
    bus_stop();
    check(stb_cnt == s0, "R2 no store", stb_cnt - s0, 0);
    check_regs("R2 regs unchanged");
  endtask

  task automatic t_wrap;
    // R6: 0x2E, 0x2F, then 0x00
    open_write(8'h2E, "R6 open");
    send_data(8'h11, "R6 ack");
    send_data(8'h22, "R6 ack");
    send_data(8'h33, "R6 ack");
    bus_stop();
    check(last_a == 0, "R6 wrapped index", last_a, 0);
    check_regs("R6 wrap contents");
  endtask

  task automatic t_ptr_limit;
    // R4: 0x3A and 0xC3 exceed the last index and load 0
    open_write(8'h3A, "R4 open");
    send_data(8'h5E, "R4 ack");
    bus_stop();
    check(last_a == 0, "R4 clamp index", last_a, 0);
    open_write(8'hC3, "R4 open");
    send_data(8'h6F, "R4 ack");
    bus_stop();
    check(last_a == 0, "R4 clamp index", last_a, 0);
    open_write(8'h2F, "R4 open last");
    send_data(8'h7A, "R4 ack");
    bus_stop();
    check(last_a == 47, "R4 last index", last_a, 47);
    check_regs("R4 contents");
  endtask

  task automatic t_stop_mid;
    int s0;
    // R7
    open_write(8'h10, "R7 open");
    send_data(8'h44, "R7 ack");
    s0 = stb_cnt;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check(stb_cnt == s0, "R7 partial discarded", stb_cnt - s0, 0);
    check(sda_oe_o == 1'b0, "R7 released", int'(sda_oe_o), 0);
    check_regs("R7 contents");
  endtask

  task automatic t_restart;
    // R8
    open_write(8'h08, "R8 open");
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    open_write(8'h09, "R8 reopen");
    send_data(8'h77, "R8 ack");
    bus_stop();
    check(last_a == 9, "R8 index", last_a, 9);
    check_regs("R8 contents");
  endtask

  task automatic t_read;
    bit ak;
    int s0 = stb_cnt;
    // R9
    bus_start();
    send_byte(DEV_RD, ak);
    check(ak, "R9 read addr ack", int'(ak), 1);
    send_byte(8'h55, ak);
    check(!ak, "R9 released after", int'(ak), 0);
    send_byte(8'h01, ak);
    check(!ak, "R9 released after", int'(ak), 0);
    bus_stop();
    check(stb_cnt == s0, "R9 no store", stb_cnt - s0, 0);
    check_regs("R9 contents");
  endtask

  task automatic t_long_burst;
    // R6: full lap overwrites earlier values
    open_write(8'h20, "R6 lap open");
    for (int i = 0; i < 52; i++) send_data(8'(i * 7 + 3), "R6 lap ack");
    bus_stop();
    check_regs("R6 lap contents");
  endtask

  bit done = 1'b0;

  initial begin
    for (int k = 0; k < NREG; k++) exp_reg[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic_write();
    t_ack_window();
    t_wrong_addr();
    t_wrap();
    t_ptr_limit();
    t_stop_mid();
    t_restart();
    t_read();
    t_long_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule